// File: doc/BRIEF.md
# Nested-Loop Copy Burst Sequencer

This block sits in front of a copy engine that moves data from a local buffer out to global memory. Software programs two loop counts through a configuration port: an inner count and an outer count. The counts are held in a configuration register. They stay in force for every later copy until another configuration write replaces them.

A copy is issued with a source base, a destination base and four strides. There is one stride per loop level for each side. On acceptance, the sequencer captures the current counts together with the copy operands. It then emits one row-burst request per iteration of a two-level nest: the outer loop encloses the inner loop, and the inner loop encloses the row burst. Each request is handed over with a valid/ready handshake. A one-cycle done pulse marks the end of each copy. A copy whose captured count is zero raises a one-cycle error pulse instead, and produces no bursts.

The burst datapath, the memory and the instruction decoding are outside this block.

Top module: `nested_copy_seq`

## Requirements
- R1: After reset both counts are 1, `cp_ready` is high, and `bu_valid`, `done` and `err` are low.
- R2: An accepted copy with inner count N and outer count M emits exactly N*M bursts. The inner index varies fastest.
- R3: The burst at outer index o and inner index i has source address `src_base + o*src_ostride + i*src_istride` and destination address `dst_base + o*dst_ostride + i*dst_istride`, both modulo 2^AW.
- R4: While `bu_valid` is high and `bu_ready` is low, `bu_valid`, `bu_src` and `bu_dst` hold their values. The indices advance only on a cycle where both are high.
- R5: `done` is high for exactly one cycle, in the cycle after the final burst of a copy is accepted. In that cycle `bu_valid` is low and `cp_ready` is high.
- R6: `cp_ready` is low while a copy is running. A copy offered during that time is not accepted and does not change the running copy's bursts.
- R7: A configuration write applies to every later copy until the next configuration write.
- R8: A configuration write made while a copy runs, or in the same cycle a copy is accepted, does not change that copy. It takes effect from the next copy.
- R9: If either captured count is 0, the copy is accepted and `err` is high for one cycle in the next cycle. No burst is emitted, and `cp_ready` stays high.
- R10: With both counts equal to 1, a copy emits a single burst at the base addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_inner | input | CW | Inner loop count to store |
| cfg_outer | input | CW | Outer loop count to store |
| cp_valid | input | 1 | Copy issue request |
| cp_ready | output | 1 | Sequencer idle, copy can be accepted |
| cp_src | input | AW | Source base address |
| cp_dst | input | AW | Destination base address |
| cp_src_istride | input | AW | Source stride per inner step |
| cp_src_ostride | input | AW | Source stride per outer step |
| cp_dst_istride | input | AW | Destination stride per inner step |
| cp_dst_ostride | input | AW | Destination stride per outer step |
| bu_valid | output | 1 | Burst request valid |
| bu_ready | input | 1 | Burst request taken by the engine |
| bu_src | output | AW | Burst source address |
| bu_dst | output | AW | Burst destination address |
| done | output | 1 | One-cycle pulse after a copy's last burst |
| err | output | 1 | One-cycle pulse for a copy with a zero count |

## Verification
The hardest case to reach from the ports is a configuration change that overlaps a copy already in flight. This includes a write that lands in the very cycle the copy is accepted, where the copy must still use the old counts. The bench provokes both timings. It pulses the configuration strobe together with the issue request, and again while bursts are stalled. It then checks that the running copy keeps its burst count and that the following copy picks up the new counts. Around this, the bench sweeps every inner/outer pair from 1 to 3 under varying back-pressure. It also offers stray copy requests throughout each run.

// File: rtl/nested_copy_seq.sv
module nested_copy_seq #(
  parameter int CW = 16,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_inner,
  input  logic [CW-1:0] cfg_outer,
  input  logic          cp_valid,
  output logic          cp_ready,
  input  logic [AW-1:0] cp_src,
  input  logic [AW-1:0] cp_dst,
  input  logic [AW-1:0] cp_src_istride,
  input  logic [AW-1:0] cp_src_ostride,
  input  logic [AW-1:0] cp_dst_istride,
  input  logic [AW-1:0] cp_dst_ostride,
  output logic          bu_valid,
  input  logic          bu_ready,
  output logic [AW-1:0] bu_src,
  output logic [AW-1:0] bu_dst,
  output logic          done,
  output logic          err
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cfg_in_q, cfg_out_q;
  logic [CW-1:0] n_in, n_out, i_idx, o_idx;
  logic [AW-1:0] s_is, s_os, d_is, d_os;
  logic [AW-1:0] src_row, dst_row, src_cur, dst_cur;
  logic          busy, done_q, err_q;

  wire accept   = cp_valid && !busy;
  wire zero_cnt = (cfg_in_q == '0) || (cfg_out_q == '0);
  wire fire     = busy && bu_ready;
  wire last_in  = (i_idx == n_in - ONE);
  wire last_out = (o_idx == n_out - ONE);
  wire [AW-1:0] src_nrow = src_row + s_os;
  wire [AW-1:0] dst_nrow = dst_row + d_os;

  assign cp_ready = !busy;
  assign bu_valid = busy;
  assign bu_src   = src_cur;
  assign bu_dst   = dst_cur;
  assign done     = done_q;
  assign err      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_in_q  <= ONE;
      cfg_out_q <= ONE;
    end else if (cfg_we) begin
      cfg_in_q  <= cfg_inner;
      cfg_out_q <= cfg_outer;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      n_in    <= ONE;
      n_out   <= ONE;
      i_idx   <= '0;
      o_idx   <= '0;
      s_is    <= '0;
      s_os    <= '0;
      d_is    <= '0;
      d_os    <= '0;
      src_row <= '0;
      dst_row <= '0;
      src_cur <= '0;
      dst_cur <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (zero_cnt) begin
          err_q <= 1'b1;
        end else begin
          busy    <= 1'b1;
          n_in    <= cfg_in_q;
          n_out   <= cfg_out_q;
          i_idx   <= '0;
          o_idx   <= '0;
          s_is    <= cp_src_istride;
          s_os    <= cp_src_ostride;
          d_is    <= cp_dst_istride;
          d_os    <= cp_dst_ostride;
          src_row <= cp_src;
          dst_row <= cp_dst;
          src_cur <= cp_src;
          dst_cur <= cp_dst;
        end
      end else if (fire) begin
        if (last_in) begin
          i_idx <= '0;
          if (last_out) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            o_idx   <= o_idx + ONE;
            src_row <= src_nrow;
            dst_row <= dst_nrow;
            src_cur <= src_nrow;
            dst_cur <= dst_nrow;
          end
        end else begin
          i_idx   <= i_idx + ONE;
          src_cur <= src_cur + s_is;
          dst_cur <= dst_cur + d_is;
        end
      end
    end
  end

  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (bu_valid && !bu_ready) |=> (bu_valid && $stable(bu_src) && $stable(bu_dst)));

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bu_valid && cp_ready));

  a_r9_err_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(cp_valid && cp_ready) && !bu_valid));

  a_r5_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

  a_r6_start_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bu_valid) |-> $past(cp_valid && cp_ready));

endmodule

// File: tb/tb_nested_copy_seq.sv
module tb_nested_copy_seq;
  localparam int CW = 16;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CW-1:0] cfg_inner = '0, cfg_outer = '0;
  logic cp_valid = 1'b0, cp_ready;
  logic [AW-1:0] cp_src = '0, cp_dst = '0;
  logic [AW-1:0] cp_src_istride = '0, cp_src_ostride = '0;
  logic [AW-1:0] cp_dst_istride = '0, cp_dst_ostride = '0;
  logic bu_valid, bu_ready = 1'b0;
  logic [AW-1:0] bu_src, bu_dst;
  logic done, err;

  int checks = 0, errors = 0, cycles = 0;
  int m_in = 1, m_out = 1;

  nested_copy_seq #(.CW(CW), .AW(AW)) dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic set_cfg(input int ci, input int co);
    cfg_we = 1'b1; cfg_inner = CW'(ci); cfg_outer = CW'(co);
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    m_in = ci; m_out = co;
  endtask

  // Starts and ends at a negedge. acc_cfg: config write in the accept cycle;
  // mid_cfg: config write during the first burst.
  task automatic run_copy(input logic [AW-1:0] bs, input logic [AW-1:0] bd,
                          input logic [AW-1:0] sis, input logic [AW-1:0] sos,
                          input logic [AW-1:0] dis, input logic [AW-1:0] dos,
                          input int stall, input bit acc_cfg, input bit mid_cfg,
                          input int ci, input int co);
    int ni, no, nb, got;
    ni = m_in; no = m_out; nb = ni * no; got = 0;
    cp_valid = 1'b1; cp_src = bs; cp_dst = bd;
    cp_src_istride = sis; cp_src_ostride = sos;
    cp_dst_istride = dis; cp_dst_ostride = dos;
    if (acc_cfg) begin cfg_we = 1'b1; cfg_inner = CW'(ci); cfg_outer = CW'(co); end
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    if (acc_cfg) begin m_in = ci; m_out = co; end
    if (nb == 0) begin
      cp_valid = 1'b0;
      chk(err == 1'b1, "R9 err pulse", longint'(err), 1);
      chk(bu_valid == 1'b0 && cp_ready == 1'b1, "R9 no burst, still ready", longint'(bu_valid), 0);
      @(posedge clk); @(negedge clk);
      chk(err == 1'b0, "R9 err one cycle", longint'(err), 0);
      chk(bu_valid == 1'b0, "R9 no burst later", longint'(bu_valid), 0);
      return;
    end
    // stray copy offered while busy
    cp_src = 32'hDEAD_0000; cp_dst = 32'hBEEF_0000;
    cp_src_istride = 32'h77; cp_dst_istride = 32'h99;
    if (mid_cfg) begin cfg_we = 1'b1; cfg_inner = CW'(ci); cfg_outer = CW'(co); end
    for (int o = 0; o < no; o++) begin
      for (int i = 0; i < ni; i++) begin
        logic [AW-1:0] es, ed;
        es = bs + AW'(o) * sos + AW'(i) * sis;
        ed = bd + AW'(o) * dos + AW'(i) * dis;
        for (int s = 0; s < ((got + stall) % 3); s++) begin
          bu_ready = 1'b0;
          chk(bu_valid == 1'b1, "R4 valid held in stall", longint'(bu_valid), 1);
          chk(bu_src == es && bu_dst == ed, "R4 address held in stall", longint'(bu_src), longint'(es));
          @(posedge clk); @(negedge clk);
          cfg_we = 1'b0;
        end
        chk(bu_valid == 1'b1, "R2 burst present", longint'(bu_valid), 1);
        chk(cp_ready == 1'b0, "R6 not ready while busy", longint'(cp_ready), 0);
        chk(bu_src == es, "R3 source address", longint'(bu_src), longint'(es));
        chk(bu_dst == ed, "R3 destination address", longint'(bu_dst), longint'(ed));
        chk(done == 1'b0, "R5 no early done", longint'(done), 0);
        if (got == nb - 1) cp_valid = 1'b0;
        bu_ready = 1'b1;
        got++;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
      end
    end
    bu_ready = 1'b0;
    if (mid_cfg) begin m_in = ci; m_out = co; end
    chk(done == 1'b1, "R5 done after last burst", longint'(done), 1);
    chk(bu_valid == 1'b0, "R2 no extra burst", longint'(bu_valid), 0);
    chk(cp_ready == 1'b1, "R5 ready with done", longint'(cp_ready), 1);
    @(posedge clk); @(negedge clk);
    chk(done == 1'b0, "R5 done one cycle", longint'(done), 0);
    chk(bu_valid == 1'b0, "R6 stray copy not taken", longint'(bu_valid), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(cp_ready == 1'b1 && bu_valid == 1'b0, "R1 idle in reset", longint'({cp_ready, bu_valid}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && err == 1'b0, "R1 no pulses after reset", longint'({done, err}), 0);
    // R1 R10: default counts of 1 give one burst at the base
    run_copy(32'h1000, 32'h8000, 4, 64, 8, 128, 0, 0, 0, 0, 0);
    // R2 R3 R7: sweep every pair, config persists per copy
    for (int co = 1; co <= 3; co++)
      for (int ci = 1; ci <= 3; ci++) begin
        set_cfg(ci, co);
        run_copy(AW'(32'h100 * ci), AW'(32'h4000 + co), AW'(ci * 4), AW'(32'h40 * co),
                 AW'(16), AW'(32'h200), ci + co, 0, 0, 0, 0);
        run_copy(32'hFFFF_FFF0, 32'h10, 32'h8, 32'h100, 32'hFFFF_FFFC, 32'h20,
                 ci, 0, 0, 0, 0);
      end
    // R8: write in the accept cycle, then mid-copy
    set_cfg(2, 2);
    run_copy(32'h0, 32'h0, 1, 10, 2, 20, 1, 1, 0, 3, 1);
    run_copy(32'h0, 32'h0, 1, 10, 2, 20, 2, 0, 1, 1, 2);
    run_copy(32'h50, 32'h60, 1, 10, 2, 20, 0, 0, 0, 0, 0);
    // R9: zero counts, then recovery
    set_cfg(0, 2);
    run_copy(32'h0, 32'h0, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    set_cfg(3, 0);
    run_copy(32'h0, 32'h0, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    set_cfg(1, 1);
    run_copy(32'h2000, 32'h3000, 4, 4, 4, 4, 0, 0, 0, 0, 0);
    summary();
  end
endmodule